// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block is the source-side controller that brings a DisplayPort main link up. After a single-cycle `start`, it sends the link rate and the lane count to the sink. It then runs the clock-recovery phase with training pattern 1 and the channel-equalisation phase with training pattern 2. Between polls it reads the sink's drive-adjust requests, turns them into one common drive setting for all active lanes and commits that setting back to the sink. Whatever the result, training ends by switching the pattern off. If a run fails at any rate other than 1.62 Gb/s, the sequence starts again once at 1.62 Gb/s.

All sink traffic goes through an abstract AUX request port: address, byte count, write data and direction. The request is held until the transaction completes with `aux_ack` or `aux_err`, and read data arrives with the acknowledge. The local transmitter settings are driven straight from the sequencer: lane-enable mask, enhanced-framing enable, pattern select and per-lane drive bytes. The two settle delays are parameters counted in clock cycles. The sequencer reports its result with a one-cycle `done` that carries `pass` and the final rate code.

Top module: `dp_link_trainer`

## Requirements
- R1: After `start`, the first AUX write goes to 0x100 and carries the rate code. The second goes to 0x101 and carries the lane count, with bit 7 set when `cfg_rev` is 0x11 or higher. `enh_frame` then follows that same rule.
- R2: Once the lane count is written, `lane_en` equals (1 << lane count) - 1.
- R3: Clock recovery writes pattern 1 to 0x102 and commits zero drive bytes to 0x103, one byte per lane. At least CR_WAIT cycles later it reads 2 status bytes from 0x202. Lane i's nibble sits at status bits [4i+3:4i].
- R4: Clock recovery succeeds when bit 0 (clock-recovery done) is set in every active lane's nibble.
- R5: Clock recovery gives up after 5 failed status reads at one voltage swing. The try count restarts whenever the committed swing (drive bits [1:0]) differs from the swing seen at the previous read.
- R6: Clock recovery stops at once when a failed read finds the committed drive with its swing-maximum flag (bit 2) set.
- R7: An adjust step reads 2 bytes from 0x206. It takes the largest swing (nibble bits [1:0]) and the largest pre-emphasis (nibble bits [3:2]) over the active lanes. A swing at or above MAX_VS becomes MAX_VS with bit 2 set. A pre-emphasis at or above MAX_PRE becomes MAX_PRE with bit 2 set. The drive byte is {pre, swing} at bits [5:3] and [2:0].
- R8: Equalisation writes pattern 2. It then makes at most 6 status reads of 3 bytes each, every read at least EQ_WAIT cycles after the previous write. It passes when bit 0 of the third byte is set and each active lane shows bits 0, 1 and 2. Otherwise it adjusts and recommits.
- R9: If any active lane lacks clock-recovery done during equalisation, the phase aborts as a failure.
- R10: Every run that reaches its end without an AUX error writes pattern 0 to 0x102 last, and `pattern` reads 0 afterwards.
- R11: A failed run at a rate code other than 0x06 restarts the whole sequence once with rate 0x06.
- R12: An `aux_err` ends the sequence in the next cycle with `done` high and `pass` low, and no further AUX requests are made.
- R13: `done` is high for exactly one cycle, with `pass` and `final_rate` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin training (taken when idle) |
| cfg_rate | input | 8 | Initial link-rate code |
| cfg_lanes | input | 3 | Lane count (1, 2 or 4) |
| cfg_rev | input | 8 | Sink capability revision |
| aux_req | output | 1 | AUX transaction request, held until ack or error |
| aux_wr | output | 1 | 1 = write, 0 = read |
| aux_addr | output | 20 | Sink register address |
| aux_len | output | 3 | Byte count |
| aux_wdata | output | NL*8 | Write bytes, byte 0 in the low bits |
| aux_ack | input | 1 | Transaction done |
| aux_err | input | 1 | Transaction failed |
| aux_rdata | input | 24 | Read bytes, byte 0 in the low bits |
| lane_en | output | NL | Local lane-enable mask |
| enh_frame | output | 1 | Enhanced framing enable |
| pattern | output | 2 | Training pattern select (0 off, 1, 2) |
| lane_drive | output | NL*8 | Drive byte per lane |
| done | output | 1 | Completion pulse |
| pass | output | 1 | Training result |
| final_rate | output | 8 | Rate code in use at completion |

## Verification
On every cycle, the embedded properties check several things: the one-cycle `done`, error termination, the bounds on try and iteration counts, the ban on adjusting once the swing maximum is reached, the 0x06 rate on a retry, the pattern being off at a pass, and a request that stays stable until it completes. The exact order and content of AUX traffic can only be shown by the bench's sink model. So can the settle gaps, the arithmetic of the adjust resolver, the try-count reset on a swing change, the six-read equalisation limit and the fallback outcome. The bench sweeps scenarios that differ in lane count, revision, rate, sink responsiveness and the point at which an error is injected.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RATE,
        S_LANES,
        S_TP1,
        S_CR_COMMIT,
        S_CR_WAIT,
        S_CR_STAT,
        S_CR_ADJ,
        S_TP2,
        S_EQ_WAIT,
        S_EQ_STAT,
        S_EQ_ADJ,
        S_EQ_COMMIT,
        S_TPOFF,
        S_DONE
    } lt_state_e;

    // Sink register addresses (decoded by the sink, so fixed)
    localparam logic [19:0] A_RATE   = 20'h00100;
    localparam logic [19:0] A_LANES  = 20'h00101;
    localparam logic [19:0] A_PAT    = 20'h00102;
    localparam logic [19:0] A_DRIVE  = 20'h00103;
    localparam logic [19:0] A_STATUS = 20'h00202;
    localparam logic [19:0] A_ADJ    = 20'h00206;

    localparam logic [7:0] RATE_LOW     = 8'h06;
    localparam logic [7:0] REV_ENH_MIN  = 8'h11;
    localparam logic [1:0] PAT_OFF      = 2'd0;
    localparam logic [1:0] PAT_CR       = 2'd1;
    localparam logic [1:0] PAT_EQ       = 2'd2;
    localparam logic [2:0] CR_TRY_LIMIT = 3'd5;
    localparam logic [2:0] EQ_LAST_ITER = 3'd5;

    typedef struct packed {
        lt_state_e   st;
        logic [7:0]  rate;
        logic [2:0]  lanes;
        logic        lanes_on;
        logic        enh;
        logic [1:0]  pat;
        logic [7:0]  drive;
        logic [1:0]  last_vs;
        logic        vs_valid;
        logic [2:0]  tries;
        logic [2:0]  eq_iter;
        logic        pass;
    } lt_regs_t;

endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = en ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/lt_adjust.sv
module lt_adjust #(
    parameter int NL      = 4,
    parameter int MAX_VS  = 3,
    parameter int MAX_PRE = 3
) (
    input  logic [NL*4-1:0] req,
    input  logic [2:0]      lane_cnt,
    output logic [7:0]      drive
);
    localparam logic [1:0] VS_CAP  = MAX_VS[1:0];
    localparam logic [1:0] PRE_CAP = MAX_PRE[1:0];

    logic [1:0] vs_max, pre_max;
    logic [2:0] vs_out, pre_out;

    always_comb begin
        vs_max  = 2'd0;
        pre_max = 2'd0;
        for (int i = 0; i < NL; i++) begin
            if (lane_cnt > 3'(i)) begin
                if (req[4*i +: 2] > vs_max)      vs_max  = req[4*i +: 2];
                if (req[4*i + 2 +: 2] > pre_max) pre_max = req[4*i + 2 +: 2];
            end
        end
        vs_out  = (vs_max  >= VS_CAP)  ? {1'b1, VS_CAP}  : {1'b0, vs_max};
        pre_out = (pre_max >= PRE_CAP) ? {1'b1, PRE_CAP} : {1'b0, pre_max};
        drive   = {2'b00, pre_out, vs_out};
    end

endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval #(
    parameter int NL = 4
) (
    input  logic [23:0] stat,
    input  logic [2:0]  lane_cnt,
    output logic        cr_all,
    output logic        eq_all
);
    logic [NL-1:0] cr_ok, full_ok;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic active;
        assign active     = lane_cnt > 3'(g);
        assign cr_ok[g]   = !active || stat[4*g];
        assign full_ok[g] = !active || (&stat[4*g +: 3]);
    end

    assign cr_all = &cr_ok;
    assign eq_all = stat[16] && (&full_ok);

endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
    import lt_pkg::*;
#(
    parameter int NL      = 4,
    parameter int CR_WAIT = 12500,
    parameter int EQ_WAIT = 50000,
    parameter int MAX_VS  = 3,
    parameter int MAX_PRE = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      cfg_rate,
    input  logic [2:0]      cfg_lanes,
    input  logic [7:0]      cfg_rev,
    output logic            aux_req,
    output logic            aux_wr,
    output logic [19:0]     aux_addr,
    output logic [2:0]      aux_len,
    output logic [NL*8-1:0] aux_wdata,
    input  logic            aux_ack,
    input  logic            aux_err,
    input  logic [23:0]     aux_rdata,
    output logic [NL-1:0]   lane_en,
    output logic            enh_frame,
    output logic [1:0]      pattern,
    output logic [NL*8-1:0] lane_drive,
    output logic            done,
    output logic            pass,
    output logic [7:0]      final_rate
);
    localparam int WAIT_MAX = (CR_WAIT > EQ_WAIT) ? CR_WAIT : EQ_WAIT;
    localparam int TW       = $clog2(WAIT_MAX + 1);

    lt_regs_t q, n;

    logic           xfer_ok, xfer_err;
    logic           cr_all, eq_all;
    logic [7:0]     adj_drive;
    logic           wait_en, wait_done;
    logic [TW-1:0]  wait_limit;
    logic [NL*8-1:0] drive_vec;
    logic [1:0]     cur_vs;
    logic [2:0]     tries_next;

    // ---------------- helpers ----------------
    lt_lane_eval #(.NL(NL)) i_eval (
        .stat     (aux_rdata),
        .lane_cnt (q.lanes),
        .cr_all   (cr_all),
        .eq_all   (eq_all)
    );

    lt_adjust #(.NL(NL), .MAX_VS(MAX_VS), .MAX_PRE(MAX_PRE)) i_adj (
        .req      (aux_rdata[NL*4-1:0]),
        .lane_cnt (q.lanes),
        .drive    (adj_drive)
    );

    assign wait_en    = (q.st == S_CR_WAIT) || (q.st == S_EQ_WAIT);
    assign wait_limit = (q.st == S_CR_WAIT) ? TW'(CR_WAIT) : TW'(EQ_WAIT);

    lt_wait_timer #(.W(TW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wait_en),
        .limit   (wait_limit),
        .expired (wait_done)
    );

    for (genvar g = 0; g < NL; g++) begin : g_drv
        assign drive_vec[g*8 +: 8]  = (q.lanes > 3'(g)) ? q.drive : 8'h00;
        assign lane_drive[g*8 +: 8] = q.lanes_on ? drive_vec[g*8 +: 8] : 8'h00;
        assign lane_en[g]           = q.lanes_on && (q.lanes > 3'(g));
    end

    // ---------------- AUX request decode ----------------
    always_comb begin
        aux_req   = 1'b1;
        aux_wr    = 1'b1;
        aux_addr  = A_RATE;
        aux_len   = 3'd1;
        aux_wdata = '0;
        unique case (q.st)
            S_RATE:  aux_wdata[7:0] = q.rate;
            S_LANES: begin
                aux_addr       = A_LANES;
                aux_wdata[7:0] = {q.enh, 4'b0000, q.lanes};
            end
            S_TP1: begin
                aux_addr       = A_PAT;
                aux_wdata[7:0] = {6'b0, PAT_CR};
            end
            S_TP2: begin
                aux_addr       = A_PAT;
                aux_wdata[7:0] = {6'b0, PAT_EQ};
            end
            S_TPOFF: begin
                aux_addr       = A_PAT;
                aux_wdata[7:0] = {6'b0, PAT_OFF};
            end
            S_CR_COMMIT, S_EQ_COMMIT: begin
                aux_addr  = A_DRIVE;
                aux_len   = 3'(NL);
                aux_wdata = drive_vec;
            end
            S_CR_STAT: begin
                aux_wr   = 1'b0;
                aux_addr = A_STATUS;
                aux_len  = 3'd2;
            end
            S_EQ_STAT: begin
                aux_wr   = 1'b0;
                aux_addr = A_STATUS;
                aux_len  = 3'd3;
            end
            S_CR_ADJ, S_EQ_ADJ: begin
                aux_wr   = 1'b0;
                aux_addr = A_ADJ;
                aux_len  = 3'd2;
            end
            default: aux_req = 1'b0;
        endcase
    end

    assign xfer_err = aux_req && aux_err;
    assign xfer_ok  = aux_req && aux_ack && !aux_err;

    // clock-recovery try bookkeeping
    assign cur_vs     = q.drive[1:0];
    assign tries_next = ((q.vs_valid && (cur_vs == q.last_vs)) ? q.tries : 3'd0) + 3'd1;

    // ---------------- next state ----------------
    always_comb begin
        n = q;
        if (xfer_err) begin
            n.st   = S_DONE;
            n.pass = 1'b0;
        end else begin
            unique case (q.st)
                S_IDLE: if (start) begin
                    n.st       = S_RATE;
                    n.rate     = cfg_rate;
                    n.lanes    = cfg_lanes;
                    n.enh      = (cfg_rev >= REV_ENH_MIN);
                    n.lanes_on = 1'b0;
                    n.pat      = PAT_OFF;
                    n.drive    = 8'h00;
                    n.pass     = 1'b0;
                end
                S_RATE: if (xfer_ok) begin
                    n.st   = S_LANES;
                    n.pass = 1'b0;
                end
                S_LANES: if (xfer_ok) begin
                    n.st       = S_TP1;
                    n.lanes_on = 1'b1;
                end
                S_TP1: if (xfer_ok) begin
                    n.st       = S_CR_COMMIT;
                    n.pat      = PAT_CR;
                    n.drive    = 8'h00;
                    n.vs_valid = 1'b0;
                    n.tries    = 3'd0;
                end
                S_CR_COMMIT: if (xfer_ok) n.st = S_CR_WAIT;
                S_CR_WAIT:   if (wait_done) n.st = S_CR_STAT;
                S_CR_STAT: if (xfer_ok) begin
                    n.last_vs  = cur_vs;
                    n.vs_valid = 1'b1;
                    n.tries    = tries_next;
                    if (cr_all)                          n.st = S_TP2;
                    else if (q.drive[2])                 n.st = S_TPOFF;
                    else if (tries_next == CR_TRY_LIMIT) n.st = S_TPOFF;
                    else                                 n.st = S_CR_ADJ;
                end
                S_CR_ADJ: if (xfer_ok) begin
                    n.drive = adj_drive;
                    n.st    = S_CR_COMMIT;
                end
                S_TP2: if (xfer_ok) begin
                    n.pat     = PAT_EQ;
                    n.eq_iter = 3'd0;
                    n.st      = S_EQ_WAIT;
                end
                S_EQ_WAIT: if (wait_done) n.st = S_EQ_STAT;
                S_EQ_STAT: if (xfer_ok) begin
                    if (!cr_all) begin
                        n.st = S_TPOFF;
                    end else if (eq_all) begin
                        n.pass = 1'b1;
                        n.st   = S_TPOFF;
                    end else if (q.eq_iter == EQ_LAST_ITER) begin
                        n.st = S_TPOFF;
                    end else begin
                        n.st = S_EQ_ADJ;
                    end
                end
                S_EQ_ADJ: if (xfer_ok) begin
                    n.drive = adj_drive;
                    n.st    = S_EQ_COMMIT;
                end
                S_EQ_COMMIT: if (xfer_ok) begin
                    n.eq_iter = q.eq_iter + 3'd1;
                    n.st      = S_EQ_WAIT;
                end
                S_TPOFF: if (xfer_ok) begin
                    n.pat = PAT_OFF;
                    if (!q.pass && (q.rate != RATE_LOW)) begin
                        n.rate = RATE_LOW;
                        n.st   = S_RATE;
                    end else begin
                        n.st = S_DONE;
                    end
                end
                S_DONE:  n.st = S_IDLE;
                default: n.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign enh_frame  = q.lanes_on && q.enh;
    assign pattern    = q.pat;
    assign done       = (q.st == S_DONE);
    assign pass       = q.pass;
    assign final_rate = q.rate;

    // ---------------- assertions ----------------
    a_r13_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && aux_err) |=> (done && !pass && !aux_req));

    a_r5_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CR_ADJ) |-> (q.tries < CR_TRY_LIMIT));

    a_r6_no_adjust_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CR_ADJ) |-> !q.drive[2]);

    a_r8_eq_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EQ_ADJ) |-> (q.eq_iter < EQ_LAST_ITER));

    a_r11_retry_low_rate: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == S_RATE) && ($past(q.st) == S_TPOFF)) |-> (q.rate == RATE_LOW));

    a_r10_pass_pattern_off: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (pattern == PAT_OFF));

    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && !aux_ack && !aux_err) |=> (aux_req && $stable(aux_addr) && $stable(aux_wr)));

endmodule

// File: tb/test_dp_link_trainer.sv
`timescale 1ns/1ps
module test_dp_link_trainer;
    localparam int NL = 4;
    localparam int CRW = 20;
    localparam int EQW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cfg_rate = 8'h0;
    logic [2:0] cfg_lanes = 3'd1;
    logic [7:0] cfg_rev = 8'h0;
    logic aux_req, aux_wr;
    logic [19:0] aux_addr;
    logic [2:0] aux_len;
    logic [NL*8-1:0] aux_wdata;
    logic aux_ack = 1'b0, aux_err = 1'b0;
    logic [23:0] aux_rdata = '0;
    logic [NL-1:0] lane_en;
    logic enh_frame;
    logic [1:0] pattern;
    logic [NL*8-1:0] lane_drive;
    logic done, pass;
    logic [7:0] final_rate;

    always #4 clk = ~clk;

    dp_link_trainer #(.NL(NL), .CR_WAIT(CRW), .EQ_WAIT(EQW), .MAX_VS(3), .MAX_PRE(2)) i_dp_link_trainer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rate(cfg_rate),
        .cfg_lanes(cfg_lanes), .cfg_rev(cfg_rev), .aux_req(aux_req),
        .aux_wr(aux_wr), .aux_addr(aux_addr), .aux_len(aux_len),
        .aux_wdata(aux_wdata), .aux_ack(aux_ack), .aux_err(aux_err),
        .aux_rdata(aux_rdata), .lane_en(lane_en), .enh_frame(enh_frame),
        .pattern(pattern), .lane_drive(lane_drive), .done(done),
        .pass(pass), .final_rate(final_rate)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // sink scenario and observation state
    int sc_crn, sc_eqn, sc_err;
    bit sc_lose;
    logic [15:0] sc_adj;
    int cyc = 0, rcnt = 0, txn = 0;
    int n_rate, n_cr, n_eq, cr_cnt, eq_cnt;
    logic [7:0] first_rate, cur_rate, lanes_byte;
    logic [1:0] last_pat;
    logic [31:0] last_commit, first_commit;
    bit have_commit;
    int last_wr_cyc, min_cr_gap, min_eq_gap, max_cr_gap;

    always @(negedge clk) begin
        cyc++;
        if (aux_ack || aux_err) begin
            aux_ack = 1'b0;
            aux_err = 1'b0;
            rcnt = 0;
        end else if (aux_req) begin
            if (rcnt == 0 && !aux_wr && aux_addr == 20'h202) begin
                if (last_pat == 2'd1) begin
                    if (cyc - last_wr_cyc < min_cr_gap) min_cr_gap = cyc - last_wr_cyc;
                    if (cyc - last_wr_cyc > max_cr_gap) max_cr_gap = cyc - last_wr_cyc;
                end else if (cyc - last_wr_cyc < min_eq_gap) min_eq_gap = cyc - last_wr_cyc;
            end
            rcnt++;
            if (rcnt == 2) begin
                if (txn == sc_err) begin
                    aux_err = 1'b1;
                end else begin
                    aux_ack = 1'b1;
                    if (aux_wr) begin
                        last_wr_cyc = cyc;
                        case (aux_addr)
                            20'h100: begin
                                n_rate++;
                                if (n_rate == 1) first_rate = aux_wdata[7:0];
                                cur_rate = aux_wdata[7:0];
                            end
                            20'h101: lanes_byte = aux_wdata[7:0];
                            20'h102: begin
                                last_pat = aux_wdata[1:0];
                                if (aux_wdata[1:0] == 2'd1) cr_cnt = 0;
                                if (aux_wdata[1:0] == 2'd2) eq_cnt = 0;
                            end
                            20'h103: begin
                                last_commit = aux_wdata;
                                if (!have_commit) first_commit = aux_wdata;
                                have_commit = 1'b1;
                            end
                            default: ;
                        endcase
                    end else if (aux_addr == 20'h206) begin
                        aux_rdata = {8'h00, sc_adj};
                    end else begin
                        aux_rdata = '0;
                        if (last_pat == 2'd1) begin
                            n_cr++; cr_cnt++;
                            for (int l = 0; l < 4; l++)
                                if (l < cfg_lanes && cr_cnt >= sc_crn) aux_rdata[4*l] = 1'b1;
                        end else begin
                            n_eq++; eq_cnt++;
                            for (int l = 0; l < 4; l++)
                                if (l < cfg_lanes) begin
                                    if (sc_lose && cur_rate != 8'h06) aux_rdata[4*l +: 4] = 4'h0;
                                    else if (eq_cnt >= sc_eqn)       aux_rdata[4*l +: 4] = 4'h7;
                                    else                             aux_rdata[4*l +: 4] = 4'h1;
                                end
                            aux_rdata[16] = (eq_cnt >= sc_eqn);
                        end
                    end
                end
                txn++;
            end
        end
    end

    logic r_pass, r_done_after;
    logic [7:0] r_rate;

    task automatic run_case(input logic [7:0] rate, input logic [2:0] ln, input logic [7:0] rev,
                            input int crn, input int eqn, input bit lose,
                            input logic [15:0] adj, input int erra);
        bit got;
        @(negedge clk);
        sc_crn = crn; sc_eqn = eqn; sc_lose = lose; sc_adj = adj; sc_err = erra;
        txn = 0; n_rate = 0; n_cr = 0; n_eq = 0; cr_cnt = 0; eq_cnt = 0;
        first_rate = 0; cur_rate = 0; lanes_byte = 0; last_pat = 0;
        last_commit = 0; first_commit = 32'hFFFF_FFFF; have_commit = 0;
        last_wr_cyc = 0; min_cr_gap = 1000000; min_eq_gap = 1000000; max_cr_gap = 0;
        cfg_rate = rate; cfg_lanes = ln; cfg_rev = rev;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
        chk(got, "watchdog expired", 0, 1);
        r_pass = pass;
        r_rate = final_rate;
        @(negedge clk);
        r_done_after = done;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(!done && !aux_req && lane_en == 0 && pattern == 0 && !pass, "reset state",
            {done, aux_req, lane_en, pattern, pass}, 0);
        rst_n = 1'b1;

        // S1: 4 lanes, rev 0x12, immediate success
        run_case(8'h14, 3'd4, 8'h12, 1, 1, 0, 16'h0000, -1);
        chk(r_pass == 1, "R4/R8 pass", r_pass, 1);
        chk(first_rate == 8'h14, "R1 rate write", first_rate, 8'h14);
        chk(lanes_byte == 8'h84, "R1 lane byte enh", lanes_byte, 8'h84);
        chk(enh_frame == 1, "R1 enh_frame", enh_frame, 1);
        chk(lane_en == 4'hF, "R2 lane_en 4", lane_en, 4'hF);
        chk(first_commit == 32'h0, "R3 zero drive commit", first_commit, 0);
        chk(n_cr == 1 && n_eq == 1, "R3/R8 status reads", {n_cr[7:0], n_eq[7:0]}, 16'h0101);
        chk(min_cr_gap >= CRW && max_cr_gap <= CRW + 2, "R3 cr settle gap", min_cr_gap, CRW);
        chk(min_eq_gap >= EQW && min_eq_gap <= EQW + 2, "R8 eq settle gap", min_eq_gap, EQW);
        chk(last_pat == 0 && pattern == 0, "R10 pattern off", {last_pat, pattern}, 0);
        chk(r_done_after == 0, "R13 done one cycle", r_done_after, 0);
        chk(r_rate == 8'h14, "R13 final rate", r_rate, 8'h14);

        // S2: 2 lanes, rev 0x10, adjust path, swing change resets tries
        run_case(8'h0A, 3'd2, 8'h10, 3, 2, 0, 16'h0025, -1);
        chk(r_pass == 1 && n_cr == 3, "R5 swing change restarts tries", n_cr, 3);
        chk(lanes_byte == 8'h02 && enh_frame == 0, "R1 no enh below 0x11", lanes_byte, 8'h02);
        chk(lane_en == 4'h3, "R2 lane_en 2", lane_en, 4'h3);
        chk(last_commit == 32'h0000_0A0A, "R7 adjust drive commit", last_commit, 32'h0A0A);
        chk(lane_drive == 32'h0000_0A0A, "R7 lane_drive", lane_drive, 32'h0A0A);
        chk(n_eq == 2, "R8 eq retries", n_eq, 2);

        // S3: swing never changes, clock recovery never locks -> 5 tries each rate
        run_case(8'h0A, 3'd1, 8'h00, 99, 1, 0, 16'h0000, -1);
        chk(n_cr == 10, "R5 five tries per rate", n_cr, 10);
        chk(r_pass == 0 && r_rate == 8'h06 && n_rate == 2, "R11 fallback once", {r_pass, r_rate}, 8'h06);
        chk(n_eq == 0 && last_pat == 0, "R10 off after cr fail", last_pat, 0);

        // S4: adjust reaches maximum swing, early stop
        run_case(8'h06, 3'd1, 8'h00, 99, 1, 0, 16'h000F, -1);
        chk(n_cr == 2, "R6 early stop at max swing", n_cr, 2);
        chk(last_commit[7:0] == 8'h37, "R7 clamp swing and pre", last_commit[7:0], 8'h37);
        chk(r_pass == 0 && n_rate == 1 && r_rate == 8'h06, "R11 no retry at low rate", n_rate, 1);

        // S5: equalisation never completes
        run_case(8'h06, 3'd4, 8'h11, 1, 99, 0, 16'h0000, -1);
        chk(n_eq == 6 && r_pass == 0, "R8 six eq reads max", n_eq, 6);
        chk(lanes_byte == 8'h84, "R1 enh at rev 0x11", lanes_byte, 8'h84);

        // S6: clock recovery lost during eq at high rate only
        run_case(8'h0A, 3'd2, 8'h00, 1, 1, 1, 16'h0000, -1);
        chk(n_eq == 2, "R9 abort on cr loss", n_eq, 2);
        chk(r_pass == 1 && r_rate == 8'h06, "R11 low-rate retry passes", r_rate, 8'h06);

        // S7: AUX error on the first drive commit
        run_case(8'h14, 3'd2, 8'h00, 1, 1, 0, 16'h0000, 3);
        chk(r_pass == 0 && r_rate == 8'h14, "R12 error fail", {r_pass, r_rate}, 8'h14);
        chk(txn == 4 && pattern == 2'd1, "R12 no further requests", txn, 4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule